// File: doc/BRIEF.md
# Preemptive Two-Channel DMA Priority Arbiter

This block decides which of two DMA channels owns the system bus for its next bus cycle. Each channel presents a request line, a mode bit (burst or cycle-steal) and its remaining transfer count. The arbiter returns a one-hot grant and a bus-request line to the transfer sequencer. The sequencer runs the granted bus cycle, pulses a done strobe when that cycle completes, and decrements the count of the channel it served.

Channel 0 always outranks channel 1. Once channel 0 has been granted, it keeps a claim on the bus until its count is exhausted. A channel 1 burst in progress is suspended at the next bus-cycle boundary and stays suspended until channel 0 has finished all of its transfers. This holds whether channel 0 runs in burst or cycle-steal mode. The suspended channel's count and address are owned outside this block, so it resumes exactly where it stopped. In cycle-steal mode the bus goes back to the CPU for at least one cycle after every transfer.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is high, and in the cycle after it, grant_o is 2'b00 and bus_req_o is 0, and no channel 0 session is open.
- R2: A channel is eligible when its request is high and its count is nonzero. Grant bit 0 is channel 0 and bit 1 is channel 1. From idle, an eligible channel 0 is granted (2'b01) in the next cycle. Channel 1 is granted (2'b10) only if channel 0 is not eligible and no channel 0 session is open.
- R3: A channel with a zero count is never granted. A done strobe for a granted channel whose count is 1 removes its grant in the next cycle.
- R4: In burst mode (mode bit 1), a granted channel keeps its grant across done strobes while its request stays high, its count is above 1 and no preemption applies.
- R5: In cycle-steal mode (mode bit 0), every done strobe of the granted channel gives grant 2'b00 in the next cycle, even when another channel is waiting.
- R6: If channel 1 is bursting and a done arrives while channel 0 is eligible (channel 1 request high, count above 1), grant becomes 2'b01 in the next cycle with no idle cycle.
- R7: While a grant is held and done is low, the grant does not change.
- R8: From channel 0's first grant until its final done, channel 1 is not granted. This includes the idle cycles between channel 0 cycle-steal transfers and cycles where channel 0's request is low.
- R9: After channel 0's final done, an eligible channel 1 is granted two cycles after that done, with one idle cycle between.
- R10: bus_req_o is high exactly when a grant bit is high.
- R11: A done strobe while no grant is held changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 2 | Transfer request, bit n for channel n |
| burst_i | input | 2 | Mode, bit n for channel n: 1 burst, 0 cycle-steal |
| cnt0_i | input | CNT_W | Remaining transfers of channel 0 |
| cnt1_i | input | CNT_W | Remaining transfers of channel 1 |
| done_i | input | 1 | Current bus cycle completed |
| grant_o | output | 2 | One-hot bus grant, bit n for channel n |
| bus_req_o | output | 1 | Bus wanted by the DMA side |

## Verification
The hardest case to reach is channel 1 being held off while channel 0 sits between cycle-steal transfers with its request low. In that state the bus is idle and channel 1 is eligible, so only the open session stops a grant. The stimulus gets there in three steps. It first grants channel 0 in cycle-steal mode with counts left. It then completes one transfer and drops the channel 0 request for several idle cycles while channel 1 keeps requesting. A separate cycle-by-cycle vector walk drives a channel 1 burst that is preempted at a done boundary, then resumed after channel 0 drains.

// File: rtl/dma_prio_arb_pkg.sv
package dma_prio_arb_pkg;

    localparam int NUM_CH  = 2;
    localparam int GRANT_W = NUM_CH;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_HI   = 2'd1,
        OWN_LO   = 2'd2
    } owner_e;

    // Per-channel view prepared for the priority picker
    typedef struct packed {
        logic req;
        logic cnt_nz;
        logic last;
        logic burst;
    } chan_view_t;

    function automatic logic chan_ready(chan_view_t v);
        return v.req && v.cnt_nz;
    endfunction

    function automatic logic [GRANT_W-1:0] owner_to_grant(owner_e o);
        logic [GRANT_W-1:0] g;
        g = '0;
        case (o)
            OWN_HI:  g[0] = 1'b1;
            OWN_LO:  g[1] = 1'b1;
            default: g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/dma_prio_arb_qual.sv
module dma_prio_arb_qual
    import dma_prio_arb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             req_i,
    input  logic             burst_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             done_i,
    input  logic             granted_i,
    output chan_view_t       view_o
);

    localparam logic [CNT_W-1:0] ONE_XFER = CNT_W'(1);

    always_comb begin
        view_o.req    = req_i;
        view_o.cnt_nz = (cnt_i != '0);
        view_o.burst  = burst_i;
        // final transfer of this channel completes in this cycle
        view_o.last   = granted_i && done_i && (cnt_i == ONE_XFER);
    end

endmodule

// File: rtl/dma_prio_arb_pick.sv
module dma_prio_arb_pick
    import dma_prio_arb_pkg::*;
(
    input  owner_e     owner_q_i,
    input  logic       hold_q_i,
    input  logic       done_i,
    input  chan_view_t hi_i,
    input  chan_view_t lo_i,
    output owner_e     owner_n_o,
    output logic       hold_n_o
);

    logic hi_rdy;
    logic lo_rdy;

    assign hi_rdy = chan_ready(hi_i);
    assign lo_rdy = chan_ready(lo_i);

    always_comb begin
        owner_n_o = owner_q_i;
        case (owner_q_i)
            OWN_NONE: begin
                if (hi_rdy) begin
                    owner_n_o = OWN_HI;
                end else if (lo_rdy && !hold_q_i) begin
                    owner_n_o = OWN_LO;
                end
            end
            OWN_HI: begin
                if (done_i && (hi_i.last || !hi_i.burst || !hi_rdy)) begin
                    owner_n_o = OWN_NONE;
                end
            end
            OWN_LO: begin
                if (done_i) begin
                    if (lo_i.last || !lo_i.burst || !lo_rdy) begin
                        owner_n_o = OWN_NONE;
                    end else if (hi_rdy) begin
                        owner_n_o = OWN_HI;   // preempt at bus-cycle boundary
                    end
                end
            end
            default: owner_n_o = OWN_NONE;
        endcase
    end

    // Channel 0 session: opened by its grant, closed by its final transfer
    assign hold_n_o = (hold_q_i || (owner_n_o == OWN_HI)) && !hi_i.last && hi_i.cnt_nz;

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_prio_arb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CH-1:0]  req_i,
    input  logic [NUM_CH-1:0]  burst_i,
    input  logic [CNT_W-1:0]   cnt0_i,
    input  logic [CNT_W-1:0]   cnt1_i,
    input  logic               done_i,
    output logic [GRANT_W-1:0] grant_o,
    output logic               bus_req_o
);

    owner_e     owner_q;
    owner_e     owner_n;
    logic       hold_q;
    logic       hold_n;
    logic [CNT_W-1:0] cnt_arr [NUM_CH];
    chan_view_t view [NUM_CH];

    assign cnt_arr[0] = cnt0_i;
    assign cnt_arr[1] = cnt1_i;

    assign grant_o   = owner_to_grant(owner_q);
    assign bus_req_o = (owner_q != OWN_NONE);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_qual
        dma_prio_arb_qual #(.CNT_W(CNT_W)) u_qual (
            .req_i     (req_i[g]),
            .burst_i   (burst_i[g]),
            .cnt_i     (cnt_arr[g]),
            .done_i    (done_i),
            .granted_i (grant_o[g]),
            .view_o    (view[g])
        );
    end

    dma_prio_arb_pick u_pick (
        .owner_q_i (owner_q),
        .hold_q_i  (hold_q),
        .done_i    (done_i),
        .hi_i      (view[0]),
        .lo_i      (view[1]),
        .owner_n_o (owner_n),
        .hold_n_o  (hold_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_NONE;
            hold_q  <= 1'b0;
        end else begin
            owner_q <= owner_n;
            hold_q  <= hold_n;
        end
    end

endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       req_i,
    input logic [1:0]       burst_i,
    input logic [CNT_W-1:0] cnt0_i,
    input logic [CNT_W-1:0] cnt1_i,
    input logic             done_i,
    input logic [1:0]       grant_o,
    input logic             bus_req_o
);

    localparam logic [CNT_W-1:0] ONE_XFER = CNT_W'(1);

    logic hi_ok;
    logic sess_hi;

    assign hi_ok = req_i[0] && (cnt0_i != '0);

    // shadow of the channel 0 session, tracked from ports only
    always_ff @(posedge clk) begin
        if (rst) begin
            sess_hi <= 1'b0;
        end else if ((grant_o[0] && done_i && cnt0_i == ONE_XFER) || cnt0_i == '0) begin
            sess_hi <= 1'b0;
        end else if (grant_o[0]) begin
            sess_hi <= 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (grant_o == 2'b00 && !bus_req_o));

    assert_hi_wins_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (grant_o == 2'b00 && hi_ok) |=> grant_o == 2'b01);

    assert_last_hi_drops_R3: assert property (@(posedge clk) disable iff (rst)
        (grant_o[0] && done_i && cnt0_i == ONE_XFER) |=> !grant_o[0]);

    assert_last_lo_drops_R3: assert property (@(posedge clk) disable iff (rst)
        (grant_o[1] && done_i && cnt1_i == ONE_XFER) |=> !grant_o[1]);

    assert_burst_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (grant_o[0] && done_i && burst_i[0] && req_i[0] && cnt0_i > ONE_XFER) |=> grant_o[0]);

    assert_steal_release_R5: assert property (@(posedge clk) disable iff (rst)
        (done_i && (grant_o & ~burst_i) != 2'b00) |=> grant_o == 2'b00);

    assert_preempt_R6: assert property (@(posedge clk) disable iff (rst)
        (grant_o == 2'b10 && done_i && burst_i[1] && req_i[1] && cnt1_i > ONE_XFER && hi_ok)
        |=> grant_o == 2'b01);

    assert_no_midcycle_switch_R7: assert property (@(posedge clk) disable iff (rst)
        (grant_o != 2'b00 && !done_i) |=> $stable(grant_o));

    assert_lo_held_off_R8: assert property (@(posedge clk) disable iff (rst)
        sess_hi |-> !grant_o[1]);

endmodule

bind dma_prio_arb dma_prio_arb_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .burst_i   (burst_i),
    .cnt0_i    (cnt0_i),
    .cnt1_i    (cnt1_i),
    .done_i    (done_i),
    .grant_o   (grant_o),
    .bus_req_o (bus_req_o)
);

// File: tb/sim_dma_prio_arb.sv
`timescale 1ns/1ps
module sim_dma_prio_arb;

    localparam int CNT_W = 8;
    localparam int NVEC  = 11;
    // [6:5] req, [4:3] mode, [2] done, [1:0] expected grant after the edge
    localparam logic [6:0] TBL [NVEC] = '{
        7'b10_10_0_10, 7'b10_10_1_10, 7'b11_10_0_10, 7'b11_10_1_01,
        7'b11_10_1_00, 7'b11_10_0_01, 7'b11_10_1_00, 7'b11_10_0_10,
        7'b11_10_1_10, 7'b11_10_1_00, 7'b11_10_0_00
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       req = 2'b00;
    logic [1:0]       mode = 2'b00;
    logic             done = 1'b0;
    logic [CNT_W-1:0] c0 = '0;
    logic [CNT_W-1:0] c1 = '0;
    logic             ld = 1'b0;
    logic [CNT_W-1:0] lv0 = '0;
    logic [CNT_W-1:0] lv1 = '0;
    logic [1:0]       grant;
    logic             bus_req;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dma_prio_arb #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .req_i(req), .burst_i(mode),
        .cnt0_i(c0), .cnt1_i(c1), .done_i(done),
        .grant_o(grant), .bus_req_o(bus_req)
    );

    // sequencer model: counts owned outside the arbiter
    always @(posedge clk) begin
        if (ld) begin
            c0 <= lv0;
            c1 <= lv1;
        end else begin
            if (done && grant[0] && c0 != 0) c0 <= c0 - 1'b1;
            if (done && grant[1] && c1 != 0) c1 <= c1 - 1'b1;
        end
    end

    function automatic string vec_tag(int k);
        case (k)
            0: return "R2";  1: return "R4";  2: return "R7";  3: return "R6";
            4: return "R5";  5: return "R8";  6: return "R3";  7: return "R9";
            8: return "R4";  default: return "R3";
        endcase
    endfunction

    task automatic cyc(input logic [1:0] r, input logic [1:0] m, input logic d,
                       input logic [1:0] exp, input string tag);
        req = r; mode = m; done = d;
        @(negedge clk);
        checks++;
        if (grant !== exp) begin
            errors++;
            $display("FAIL %s grant=%b expected %b", tag, grant, exp);
        end
        checks++;
        if (bus_req !== (exp != 2'b00)) begin
            errors++;
            $display("FAIL R10 bus_req=%b expected %b", bus_req, exp != 2'b00);
        end
    endtask

    task automatic load(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
        req = 2'b00; done = 1'b0; ld = 1'b1; lv0 = a; lv1 = b;
        @(negedge clk);
        ld = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; req = 2'b00; done = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: held in reset with both channels requesting
        load(8'd2, 8'd4);
        cyc(2'b11, 2'b11, 1'b0, 2'b00, "R1");
        cyc(2'b11, 2'b11, 1'b1, 2'b00, "R1");
        rst = 1'b0;

        // vector walk: channel 1 burst preempted by cycle-steal channel 0
        for (int k = 0; k < NVEC; k++) begin
            cyc(TBL[k][6:5], TBL[k][4:3], TBL[k][2], TBL[k][1:0], vec_tag(k));
        end

        // R2 / R4 / R3 / R9: simultaneous requests, channel 0 burst
        do_reset();
        load(8'd3, 8'd3);
        cyc(2'b11, 2'b11, 1'b0, 2'b01, "R2");
        cyc(2'b11, 2'b11, 1'b1, 2'b01, "R4");
        cyc(2'b11, 2'b11, 1'b0, 2'b01, "R7");
        cyc(2'b11, 2'b11, 1'b1, 2'b01, "R4");
        cyc(2'b11, 2'b11, 1'b1, 2'b00, "R3");
        cyc(2'b11, 2'b11, 1'b0, 2'b10, "R9");

        // R8: channel 0 cycle-steal session with its request dropped in the gap
        do_reset();
        load(8'd3, 8'd3);
        cyc(2'b11, 2'b00, 1'b0, 2'b01, "R2");
        cyc(2'b11, 2'b00, 1'b1, 2'b00, "R5");
        cyc(2'b10, 2'b00, 1'b0, 2'b00, "R8");
        cyc(2'b10, 2'b00, 1'b0, 2'b00, "R8");
        cyc(2'b10, 2'b00, 1'b0, 2'b00, "R8");
        cyc(2'b11, 2'b00, 1'b0, 2'b01, "R8");
        cyc(2'b11, 2'b00, 1'b1, 2'b00, "R5");
        cyc(2'b11, 2'b00, 1'b0, 2'b01, "R8");
        cyc(2'b11, 2'b00, 1'b1, 2'b00, "R3");
        cyc(2'b11, 2'b00, 1'b0, 2'b10, "R9");
        cyc(2'b11, 2'b00, 1'b1, 2'b00, "R5");
        cyc(2'b11, 2'b00, 1'b0, 2'b10, "R5");
        cyc(2'b11, 2'b00, 1'b1, 2'b00, "R5");

        // R11: done strobes while idle, then a normal channel 1 burst
        do_reset();
        load(8'd0, 8'd2);
        cyc(2'b00, 2'b00, 1'b1, 2'b00, "R11");
        cyc(2'b00, 2'b00, 1'b1, 2'b00, "R11");
        cyc(2'b10, 2'b10, 1'b0, 2'b10, "R11");
        cyc(2'b10, 2'b10, 1'b1, 2'b10, "R4");
        cyc(2'b10, 2'b10, 1'b1, 2'b00, "R3");

        // R3: requests with zero counts are never granted
        cyc(2'b11, 2'b11, 1'b0, 2'b00, "R3");
        cyc(2'b11, 2'b11, 1'b0, 2'b00, "R3");

        // R5 / R7: cycle-steal channel 1 not preempted mid-cycle, releases the bus
        do_reset();
        load(8'd1, 8'd2);
        cyc(2'b10, 2'b00, 1'b0, 2'b10, "R2");
        cyc(2'b11, 2'b00, 1'b0, 2'b10, "R7");
        cyc(2'b11, 2'b00, 1'b1, 2'b00, "R5");
        cyc(2'b11, 2'b00, 1'b0, 2'b01, "R2");
        cyc(2'b11, 2'b00, 1'b1, 2'b00, "R3");
        cyc(2'b11, 2'b00, 1'b0, 2'b10, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule